// File: doc/BRIEF.md
# Adaptive On-Time Switching Sequencer

This block sequences the two power switches of one synchronous buck phase without a free-running oscillator. Analog comparators outside the block report five digital flags to it: a valley request that asks for a new conduction cycle, a zero inductor current flag, an overcurrent flag, a flag that the switch node has fallen low, and a flag that the low-side gate has discharged. From these flags it drives a high-side enable and a low-side enable.

Each cycle turns the high side on for a fixed count of clock cycles taken from a one-shot counter. A two-bit frequency select picks one of four on-time presets. After the high side turns off, the low side conducts for the rest of the off phase. In skip mode it stops at the zero-current point. In forced-continuous mode it ignores that point. Dead time in both directions comes from a handshake with the switch-node and gate sense flags rather than from fixed delays. A start-up guard keeps the low side off until the first high-side pulse. An overcurrent condition holds off new cycles. A synchronous halt input returns the phase to a safe idle state.

Top module: `aot_sequencer`

## Requirements
- R1: While reset is asserted, and on the first sample after it, both `hs_en` and `ls_en` are low.
- R2: A request served with `oc_det` low and `lsg_low` high raises `hs_en` for exactly TON clock cycles. TON is the on-time for the `fsel` code divided by `CLK_NS` using integer division, with a minimum of 1. The on-times are: code 0 = 2340 ns, code 1 = 1950 ns, code 2 = 1490 ns, code 3 = 1111 ns.
- R3: After `hs_en` falls, `ls_en` rises only once `sw_low` has been sampled high. While `sw_low` stays low, both enables remain low.
- R4: `hs_en` rises only in the cycle after `lsg_low` was sampled high. A request made while the low side conducts first drops `ls_en`. It then waits for `lsg_low`.
- R5: With `fccm` = 0, a high `zc_det` while `ls_en` is high drops `ls_en` on the next cycle, and it stays low until after the next high-side pulse.
- R6: With `fccm` = 1, `zc_det` is ignored and `ls_en` stays high until the next request.
- R7: After reset or halt, `ls_en` stays low in either mode until `hs_en` has been high at least once.
- R8: While `oc_det` is high, no high-side pulse starts. A request made in that time is kept and served once `oc_det` falls.
- R9: A request that arrives during the on-time or during a dead-time wait is kept and produces exactly one further high-side pulse once that pulse is legal.
- R10: `hs_en` and `ls_en` are never high in the same cycle.
- R11: A high `halt` forces both enables low on the next cycle. It also drops any kept request and re-arms the start-up guard of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Synchronous disable |
| set_req | input | 1 | Valley request for a new on-cycle |
| zc_det | input | 1 | Zero inductor current flag |
| oc_det | input | 1 | Overcurrent flag |
| sw_low | input | 1 | Switch node sensed low |
| lsg_low | input | 1 | Low-side gate sensed low |
| fccm | input | 1 | 1 = forced-continuous, 0 = skip |
| fsel | input | 2 | On-time preset select |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bench sweeps all four on-time codes in both conduction modes and measures each pulse width against the preset computed from the nanosecond values. An off-by-one counter would show up as a width one cycle long or short. The bench holds each sense flag low on purpose to catch an enable that fires before the dead-time handshake; such a fault would cause shoot-through. It also raises overcurrent and sends late requests to catch a design that drops a kept request, serves it twice, or starts a pulse against the current limit. Halt is applied in the middle of a pulse to expose a start-up guard that is not re-armed, which would let the low side discharge a pre-charged output.

// File: rtl/aot_sequencer.sv
module aot_sequencer #(
  parameter int CLK_NS  = 10,
  parameter int TON_NS0 = 2340,
  parameter int TON_NS1 = 1950,
  parameter int TON_NS2 = 1490,
  parameter int TON_NS3 = 1111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       set_req,
  input  logic       zc_det,
  input  logic       oc_det,
  input  logic       sw_low,
  input  logic       lsg_low,
  input  logic       fccm,
  input  logic [1:0] fsel,
  output logic       hs_en,
  output logic       ls_en
);
  localparam int T0 = (TON_NS0 / CLK_NS < 1) ? 1 : TON_NS0 / CLK_NS;
  localparam int T1 = (TON_NS1 / CLK_NS < 1) ? 1 : TON_NS1 / CLK_NS;
  localparam int T2 = (TON_NS2 / CLK_NS < 1) ? 1 : TON_NS2 / CLK_NS;
  localparam int T3 = (TON_NS3 / CLK_NS < 1) ? 1 : TON_NS3 / CLK_NS;
  localparam int TA = (T0 > T1) ? T0 : T1;
  localparam int TB = (T2 > T3) ? T2 : T3;
  localparam int TMAX = (TA > TB) ? TA : TB;
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {ST_OFF, ST_HS, ST_DTH, ST_LS, ST_DTL} st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, preset;
  logic pend, armed;
  logic req, go, start;

  always_comb begin
    case (fsel)
      2'd0:    preset = CW'(T0);
      2'd1:    preset = CW'(T1);
      2'd2:    preset = CW'(T2);
      default: preset = CW'(T3);
    endcase
  end

  assign req = pend | set_req;
  assign go  = req & ~oc_det & lsg_low;

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF: if (go) nxt = ST_HS;
              else if (fccm && armed && sw_low) nxt = ST_LS;
      ST_HS:  if (cnt == '0) nxt = ST_DTH;
      ST_DTH: if (sw_low) nxt = ST_LS;
      ST_LS:  if (req && !oc_det) nxt = ST_DTL;
              else if (zc_det && !fccm) nxt = ST_OFF;
      ST_DTL: if (go) nxt = ST_HS;
      default: nxt = ST_OFF;
    endcase
    if (halt) nxt = ST_OFF;
  end

  assign start = (nxt == ST_HS) && (st != ST_HS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_OFF;
      cnt   <= '0;
      pend  <= 1'b0;
      armed <= 1'b0;
    end else begin
      st <= nxt;
      if (start) cnt <= preset - CW'(1);
      else if (st == ST_HS && cnt != '0) cnt <= cnt - CW'(1);
      pend <= (halt || start) ? 1'b0 : req;
      if (halt) armed <= 1'b0;
      else if (start) armed <= 1'b1;
    end
  end

  assign hs_en = (st == ST_HS);
  assign ls_en = (st == ST_LS);

  p_ls_after_sw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> $past(sw_low));
  p_hs_after_lsg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> $past(lsg_low));
  p_no_start_oc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> !$past(oc_det));
  p_skip_zc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_en && zc_det && !fccm) |=> !ls_en);
  p_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> armed);
  p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!hs_en && !ls_en));
  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> !$past(ls_en));
endmodule

// File: tb/aot_sequencer_tb.sv
module aot_sequencer_tb;
  localparam int CLK_NS = 50;
  logic clk = 1'b0;
  logic rst_n, halt, set_req, zc_det, oc_det, fccm, hold_sw, hold_lg;
  logic [1:0] fsel;
  logic hs_en, ls_en, sw_low, lsg_low;
  int n_chk = 0, n_fail = 0, overlap = 0;

  always #10 clk = ~clk;

  assign sw_low  = ~hs_en & ~hold_sw;
  assign lsg_low = ~ls_en & ~hold_lg;

  aot_sequencer #(.CLK_NS(CLK_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .set_req(set_req), .zc_det(zc_det),
    .oc_det(oc_det), .sw_low(sw_low), .lsg_low(lsg_low), .fccm(fccm),
    .fsel(fsel), .hs_en(hs_en), .ls_en(ls_en));

  function automatic int exp_ton(input int f);
    int ns;
    case (f)
      0: ns = 2340;
      1: ns = 1950;
      2: ns = 1490;
      default: ns = 1111;
    endcase
    return (ns / CLK_NS < 1) ? 1 : ns / CLK_NS;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set();
    @(negedge clk) set_req = 1'b1;
    @(negedge clk) set_req = 1'b0;
  endtask

  task automatic measure(output int w, input int tmo);
    int t = 0;
    w = 0;
    while (!hs_en && t < tmo) begin @(negedge clk); t++; end
    while (hs_en && w < 10000) begin w++; @(negedge clk); end
  endtask

  always @(negedge clk) if (rst_n && hs_en && ls_en) overlap++;

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w, rises;
    rst_n = 0; halt = 0; set_req = 0; zc_det = 0; oc_det = 0;
    fccm = 0; hold_sw = 0; hold_lg = 0; fsel = 0;
    cyc(3);
    check(!hs_en && !ls_en, "R1 reset", {hs_en, ls_en}, 0);
    rst_n = 1;
    cyc(1);
    check(!hs_en && !ls_en, "R1 after reset", {hs_en, ls_en}, 0);

    for (int f = 0; f < 4; f++) begin
      for (int m = 0; m < 2; m++) begin
        fsel = 2'(f); fccm = m[0];
        cyc(2);
        pulse_set();
        measure(w, 50);
        check(w == exp_ton(f), "R2 on-time", w, exp_ton(f));
        cyc(3);
        check(ls_en, "R3 low side after on-time", ls_en, 1);
        zc_det = 1'b1;
        cyc(2);
        if (m == 0) check(!ls_en, "R5 zero-cross off", ls_en, 0);
        else        check(ls_en, "R6 zero-cross ignored", ls_en, 1);
        zc_det = 1'b0;
        cyc(3);
        if (m == 0) check(!ls_en, "R5 stays off", ls_en, 0);
        else        check(ls_en, "R6 stays on", ls_en, 1);
      end
    end

    fsel = 2'd3;
    halt = 1'b1; fccm = 1'b1;
    cyc(2);
    check(!hs_en && !ls_en, "R11 halt idle", {hs_en, ls_en}, 0);
    halt = 1'b0;
    cyc(10);
    check(!ls_en, "R7 guard after halt", ls_en, 0);
    pulse_set();
    measure(w, 50);
    check(w == exp_ton(3), "R2 first pulse", w, exp_ton(3));
    cyc(3);
    check(ls_en, "R7 low side after first pulse", ls_en, 1);

    hold_sw = 1'b1;
    pulse_set();
    measure(w, 50);
    cyc(5);
    check(!ls_en && !hs_en, "R3 wait switch node", {hs_en, ls_en}, 0);
    hold_sw = 1'b0;
    cyc(3);
    check(ls_en, "R3 released", ls_en, 1);

    hold_lg = 1'b1;
    pulse_set();
    cyc(5);
    check(!hs_en && !ls_en, "R4 wait gate low", {hs_en, ls_en}, 0);
    hold_lg = 1'b0;
    measure(w, 20);
    check(w == exp_ton(3), "R4 served", w, exp_ton(3));
    cyc(3);

    oc_det = 1'b1;
    pulse_set();
    cyc(10);
    check(!hs_en && ls_en, "R8 blocked", {hs_en, ls_en}, 1);
    oc_det = 1'b0;
    measure(w, 20);
    check(w == exp_ton(3), "R8 kept request", w, exp_ton(3));
    cyc(3);

    fork
      pulse_set();
      begin
        int t = 0;
        while (!hs_en && t < 20) begin @(negedge clk); t++; end
        cyc(3);
        pulse_set();
      end
    join
    measure(w, 0);
    measure(w, 20);
    check(w == exp_ton(3), "R9 pending pulse", w, exp_ton(3));
    rises = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (hs_en) rises++;
    end
    check(rises == 0, "R9 exactly one extra", rises, 0);

    pulse_set();
    measure(w, 0);
    begin
      int t = 0;
      while (!hs_en && t < 20) begin @(negedge clk); t++; end
    end
    cyc(2);
    set_req = 1'b1;
    @(negedge clk) set_req = 1'b0; halt = 1'b1;
    @(negedge clk);
    check(!hs_en && !ls_en, "R11 halt forces low", {hs_en, ls_en}, 0);
    halt = 1'b0;
    rises = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (hs_en || ls_en) rises++;
    end
    check(rises == 0, "R11 request dropped and guard re-armed", rises, 0);

    check(overlap == 0, "R10 exclusive enables", overlap, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule